// File: doc/BRIEF.md
# Synchronous Divide-by-60 BCD Counter

This block is a modulo-60 counter with two decimal digits. A low digit counts from 0 to 9, and a high digit counts from 0 to 5. Both digits are held in registers that share a single clock, so no stage uses another stage's output as its clock. Each cycle in which the count enable is high moves the pair forward by one step. The high digit moves only on a cycle where the low digit is leaving 9. The high digit wraps by decoding the value 6 and forcing the result back to 0.

The carry output goes high on the enabled cycle where the pair holds 59. It is intended to drive the enable of a following stage, and it produces one pulse for every sixty enabled input cycles. Its typical use is to turn a line-rate tick into a once-per-second tick.

Top module: `div60_chain`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces both digits to 0 on that edge, whatever `cnt_en` is.
- R2: While `cnt_en` is low and `rst` is low, neither digit changes and `carry_out` stays low.
- R3: On an enabled edge where the low digit is below 9, the low digit increases by exactly one.
- R4: The low digit detects the value 9 (binary 1001) from its bit 3 and bit 0 alone. On the next enabled edge it returns to 0.
- R5: The high digit changes only on an enabled edge where the low digit holds 9. On such an edge it increases by one when it is below 5.
- R6: On the enabled edge where the pair holds 59 (high digit 5, low digit 9), both digits return to 0 together. The decoded value 6 never appears on the high digit.
- R7: `carry_out` is a combinational decode. It is high exactly when `cnt_en` is high, the low digit is 9 and the high digit is 5.
- R8: Under continuous enable, `carry_out` is high for one cycle in every 60. The pulses are 60 enabled cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for every register |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable: advances the chain and qualifies the carry |
| units_bcd | output | 4 | Low decimal digit, 0 to 9 |
| tens_bcd | output | 4 | High decimal digit, 0 to 5 |
| carry_out | output | 1 | Terminal-count pulse at 59, used to enable a following stage |

## Verification
Reset and the combined wrap at 59 can fall on the same edge. So can a dropped enable and the terminal state. The bench steps the chain to 59 and then asserts reset with the enable still high. It also parks the chain at 59 with the enable low. It expects reset to win in the first case. In the second case it expects the digits to hold and the carry to drop. An irregular enable pattern runs through several full wraps. Throughout, a behavioural model in integers is compared against every output on every cycle.

// File: rtl/div60_pkg.sv
package div60_pkg;
    localparam int DIGIT_W = 4;
    typedef logic [DIGIT_W-1:0] digit_t;

    typedef struct packed {
        digit_t digit;
    } stage_state_t;
endpackage

// File: rtl/div60_units_stage.sv
module div60_units_stage
    import div60_pkg::*;
#(
    parameter int LAST = 9
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    output digit_t value,
    output logic   at_last
);
    localparam digit_t LAST_V = digit_t'(LAST);

    stage_state_t st_d, st_q;
    logic         last_hit;

    generate
        if (LAST == 9) begin : g_partial
            // 1001 is the first state with bits 3 and 0 both set
            assign last_hit = st_q.digit[3] & st_q.digit[0];
        end else begin : g_full
            assign last_hit = (st_q.digit == LAST_V);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.digit = '0;
        end else if (en) begin
            if (last_hit) st_d.digit = '0;
            else          st_d.digit = st_q.digit + digit_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign value   = st_q.digit;
    assign at_last = last_hit;

    // R1
    units_reset_chk: assert property (@(posedge clk)
        rst |=> value == '0);
    // R2
    units_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(value));
    // R3
    units_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && value < LAST_V) |=> value == digit_t'($past(value) + 1));
    // R4
    units_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (en && value == LAST_V) |=> value == '0);
endmodule

// File: rtl/div60_tens_stage.sv
module div60_tens_stage
    import div60_pkg::*;
#(
    parameter int WRAP = 6
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   adv,
    output digit_t value,
    output logic   at_last
);
    localparam digit_t WRAP_V = digit_t'(WRAP);
    localparam digit_t LAST_V = digit_t'(WRAP - 1);

    stage_state_t st_d, st_q;
    digit_t       incr;

    always_comb begin
        incr = st_q.digit + digit_t'(1);
        st_d = st_q;
        if (rst) begin
            st_d.digit = '0;
        end else if (adv) begin
            // decode of the wrap value recycles the digit
            st_d.digit = (incr == WRAP_V) ? digit_t'(0) : incr;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign value   = st_q.digit;
    assign at_last = (st_q.digit == LAST_V);

    // R5
    tens_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(value));
    // R5
    tens_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && value < LAST_V) |=> value == digit_t'($past(value) + 1));
    // R6
    tens_range_chk: assert property (@(posedge clk) disable iff (rst)
        value < WRAP_V);
endmodule

// File: rtl/div60_chain.sv
module div60_chain
    import div60_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cnt_en,
    output logic [3:0] units_bcd,
    output logic [3:0] tens_bcd,
    output logic       carry_out
);
    digit_t u_val, t_val;
    logic   u_last, t_last;
    logic   tens_adv;

    div60_units_stage #(.LAST(9)) u_units (
        .clk     (clk),
        .rst     (rst),
        .en      (cnt_en),
        .value   (u_val),
        .at_last (u_last)
    );

    assign tens_adv = cnt_en & u_last;

    div60_tens_stage #(.WRAP(6)) u_tens (
        .clk     (clk),
        .rst     (rst),
        .adv     (tens_adv),
        .value   (t_val),
        .at_last (t_last)
    );

    assign units_bcd = u_val;
    assign tens_bcd  = t_val;
    assign carry_out = cnt_en & u_last & t_last;

    // R6
    joint_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && units_bcd == 4'd9 && tens_bcd == 4'd5)
            |=> (units_bcd == 4'd0 && tens_bcd == 4'd0));
    // R7
    carry_decode_chk: assert property (@(posedge clk) disable iff (rst)
        carry_out |-> (cnt_en && units_bcd == 4'd9 && tens_bcd == 4'd5));
    // R2
    carry_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |-> !carry_out);
endmodule

// File: tb/div60_chain_bench.sv
`timescale 1ns/1ps
module div60_chain_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [3:0] units_bcd, tens_bcd;
    logic       carry_out;

    int checks = 0;
    int errors = 0;
    int m_u = 0;
    int m_t = 0;
    int en_cycles = 0;
    int last_tc = -1;
    int tc_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    div60_chain u_div60_chain (
        .clk(clk), .rst(rst), .cnt_en(cnt_en),
        .units_bcd(units_bcd), .tens_bcd(tens_bcd), .carry_out(carry_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic e, input string req);
        bit exp_tc;
        rst = r; cnt_en = e;
        #1;
        exp_tc = e && m_u == 9 && m_t == 5;
        chk(carry_out == exp_tc, {req, " R7 carry"}, carry_out, exp_tc);
        if (carry_out && e && !r) begin
            if (last_tc >= 0)
                chk(en_cycles - last_tc == 60, "R8 carry spacing", en_cycles - last_tc, 60);
            last_tc = en_cycles;
            tc_seen++;
        end
        @(posedge clk);
        if (r) begin
            m_u = 0; m_t = 0;
        end else if (e) begin
            en_cycles++;
            if (m_u == 9) begin
                m_u = 0;
                m_t = (m_t == 5) ? 0 : m_t + 1;
            end else begin
                m_u = m_u + 1;
            end
        end
        @(negedge clk);
        chk(units_bcd == m_u, {req, " units"}, units_bcd, m_u);
        chk(tens_bcd == m_t, {req, " tens"}, tens_bcd, m_t);
    endtask

    initial begin
        @(negedge clk);
        step(1, 0, "R1 reset");
        step(1, 1, "R1 reset with enable");
        // R3 R4 R5 R6 R8: continuous count through two full wraps
        for (int i = 0; i < 130; i++) step(0, 1, "R3 R4 R5 R6 count");
        chk(tc_seen == 2, "R8 pulse count", tc_seen, 2);
        // R2: irregular enable pattern
        for (int i = 0; i < 200; i++) step(0, (i % 3) != 1, "R2 gated count");
        // park at 59 with enable low
        while (!(m_u == 9 && m_t == 5)) step(0, 1, "R6 approach");
        for (int i = 0; i < 4; i++) step(0, 0, "R2 hold at 59");
        step(0, 1, "R6 wrap from 59");
        // reset colliding with wrap at 59
        while (!(m_u == 9 && m_t == 5)) step(0, 1, "R6 approach");
        step(1, 1, "R1 reset at 59");
        step(0, 1, "R3 after reset");
        // reset in mid count
        for (int i = 0; i < 23; i++) step(0, 1, "R5 count");
        step(1, 0, "R1 reset mid count");
        step(0, 0, "R2 idle");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule